// File: doc/BRIEF.md
# Audio Transmit Channel Interrupt Status

This block turns the transmit FIFO condition flags of one audio channel into interrupt status. It keeps a raw status vector with three live bits: FIFO half empty, transmission complete, and a sticky underrun. It masks that vector with a software-written enable vector and drives one level-sensitive interrupt line. Software removes the underrun condition by writing a one to the underrun position of a write-one-to-clear register. The raw vector is also presented on a read-data bus, zero-extended.

The raw vector is not tracked continuously. It is refreshed only when a refresh event occurs. A refresh event is any register write (configuration, enable or clear) or a drain attempt from the codec side. The sticky underrun is kept by a two-state machine. In `UR_QUIET` no underrun is pending. Transition LATCH goes to `UR_LATCHED` on an underrun event. Transition CLEAR returns to `UR_QUIET` on a clear write carrying the underrun bit when no new underrun event arrives in the same cycle. Transition DISABLE forces `UR_QUIET` from either state while the interface enable is low. When the interface enable is low, every status bit is also held at zero.

Top module: `chan_irq_status`

## Requirements
- R1: After reset, raw_stat, masked_stat, irq and rd_data are all zero.
- R2: On a refresh event, raw bit 0 takes the value of fifo_half_empty.
- R3: On a refresh event, raw bit 1 is set only if fifo_empty is high and tx_busy is low.
- R4: An underrun event (fifo_underrun high) sets raw bit 2 at the refresh in the same cycle or a later one. The bit stays set through further refreshes whatever the FIFO flags are.
- R5: A clear write (clr_wr) with clr_wdata bit 2 set clears raw bit 2. A clear write with bit 2 low has no effect on it. An underrun event in the same cycle as the clear keeps the bit set.
- R6: Without a refresh event (drain_evt, cfg_wr, ien_wr or clr_wr), raw_stat holds its value whatever the FIFO flags do.
- R7: masked_stat equals raw_stat ANDed with the enable vector, which is loaded from ien_wdata when ien_wr is high.
- R8: irq is registered: one clock edge after masked_stat becomes nonzero it is high, and one edge after masked_stat becomes zero it is low.
- R9: While if_en is low, raw_stat is zero from the next edge and any latched underrun is discarded.
- R10: rd_data carries raw_stat in its low 7 bits and zero in every higher bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_en | input | 1 | Global interface enable |
| drain_evt | input | 1 | Drain attempt from the codec side (refresh) |
| cfg_wr | input | 1 | Write to any other channel register (refresh) |
| fifo_underrun | input | 1 | Underrun event from the FIFO drain |
| fifo_half_empty | input | 1 | FIFO at or below half full |
| fifo_empty | input | 1 | FIFO holds no samples |
| tx_busy | input | 1 | Transmitter still shifting |
| ien_wr | input | 1 | Enable-register write strobe (refresh) |
| ien_wdata | input | STAT_W | Enable-register write data |
| clr_wr | input | 1 | Clear-register write strobe (refresh) |
| clr_wdata | input | STAT_W | Clear-register write data, bit 2 clears underrun |
| raw_stat | output | STAT_W | Raw interrupt status |
| masked_stat | output | STAT_W | Raw status ANDed with enables |
| irq | output | 1 | Registered interrupt line |
| rd_data | output | DATA_W | Raw status zero-extended for reads |

## Verification
raw_stat, masked_stat and rd_data reflect a refresh or disable on the first clock edge after the stimulus cycle. irq lags them by one more edge. The bench drives each stimulus cycle at the falling edge and queues one expected record for it. The monitor compares that record shortly after the following rising edge. The expected irq in each record is taken from the previous record's masked value, so the extra register stage is checked on every cycle.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
    localparam int STAT_W_DEF = 7;
    localparam int BIT_TXHALF = 0;
    localparam int BIT_TXDONE = 1;
    localparam int BIT_UNDER  = 2;

    typedef enum logic [0:0] {
        UR_QUIET   = 1'b0,
        UR_LATCHED = 1'b1
    } ur_state_e;
endpackage

// File: rtl/underrun_tracker.sv
module underrun_tracker
    import chan_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic if_en,
    input  logic underrun_evt,
    input  logic clr_hit,
    output logic ur_next
);
    ur_state_e state_q, state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (!if_en) begin
            state_d = UR_QUIET;                 // DISABLE
        end else begin
            unique case (state_q)
                UR_QUIET:   if (underrun_evt) state_d = UR_LATCHED;             // LATCH
                UR_LATCHED: if (clr_hit && !underrun_evt) state_d = UR_QUIET;   // CLEAR
                default:    state_d = UR_QUIET;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UR_QUIET;
        else        state_q <= state_d;
    end

    // output: status seen by a refresh taken this cycle
    always_comb begin
        ur_next = (state_d == UR_LATCHED);
    end
endmodule

// File: rtl/status_former.sv
module status_former
    import chan_irq_pkg::*;
#(
    parameter int STAT_W = STAT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_en,
    input  logic              refresh,
    input  logic              half_empty,
    input  logic              empty,
    input  logic              busy,
    input  logic              ur_next,
    output logic [STAT_W-1:0] raw_q
);
    logic [STAT_W-1:0] fresh;

    always_comb begin
        fresh             = '0;
        fresh[BIT_TXHALF] = half_empty;
        fresh[BIT_TXDONE] = empty & ~busy;
        fresh[BIT_UNDER]  = ur_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        raw_q <= '0;
        else if (!if_en)   raw_q <= '0;
        else if (refresh)  raw_q <= fresh;
    end
endmodule

// File: rtl/irq_driver.sv
module irq_driver
    import chan_irq_pkg::*;
#(
    parameter int STAT_W = STAT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ien_wr,
    input  logic [STAT_W-1:0] ien_wdata,
    input  logic [STAT_W-1:0] raw,
    output logic [STAT_W-1:0] masked,
    output logic              irq_q
);
    logic [STAT_W-1:0] ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= ien_wdata;
    end

    assign masked = raw & ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |masked;
    end
endmodule

// File: rtl/chan_irq_status.sv
module chan_irq_status
    import chan_irq_pkg::*;
#(
    parameter int STAT_W = STAT_W_DEF,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_en,
    input  logic              drain_evt,
    input  logic              cfg_wr,
    input  logic              fifo_underrun,
    input  logic              fifo_half_empty,
    input  logic              fifo_empty,
    input  logic              tx_busy,
    input  logic              ien_wr,
    input  logic [STAT_W-1:0] ien_wdata,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_wdata,
    output logic [STAT_W-1:0] raw_stat,
    output logic [STAT_W-1:0] masked_stat,
    output logic              irq,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - STAT_W;

    logic refresh;
    logic clr_hit;
    logic ur_next;

    assign refresh = drain_evt | cfg_wr | ien_wr | clr_wr;
    assign clr_hit = clr_wr & clr_wdata[BIT_UNDER];

    underrun_tracker u_ur (
        .clk          (clk),
        .rst_n        (rst_n),
        .if_en        (if_en),
        .underrun_evt (fifo_underrun),
        .clr_hit      (clr_hit),
        .ur_next      (ur_next)
    );

    status_former #(.STAT_W(STAT_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .if_en      (if_en),
        .refresh    (refresh),
        .half_empty (fifo_half_empty),
        .empty      (fifo_empty),
        .busy       (tx_busy),
        .ur_next    (ur_next),
        .raw_q      (raw_stat)
    );

    irq_driver #(.STAT_W(STAT_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ien_wr    (ien_wr),
        .ien_wdata (ien_wdata),
        .raw       (raw_stat),
        .masked    (masked_stat),
        .irq_q     (irq)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, raw_stat};
        end else begin : g_trunc
            assign rd_data = raw_stat[DATA_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/chan_irq_status_chk.sv
module chan_irq_status_chk #(
    parameter int STAT_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              if_en,
    input logic              drain_evt,
    input logic              cfg_wr,
    input logic              fifo_underrun,
    input logic              fifo_empty,
    input logic              tx_busy,
    input logic              ien_wr,
    input logic              clr_wr,
    input logic [STAT_W-1:0] clr_wdata,
    input logic [STAT_W-1:0] raw_stat,
    input logic [STAT_W-1:0] masked_stat,
    input logic              irq
);
    // R3
    txdone_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (if_en && drain_evt && fifo_empty && !tx_busy) |=> raw_stat[1]);

    // R4
    underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (if_en && drain_evt && fifo_underrun) |=> raw_stat[2]);

    // R5
    underrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (if_en && clr_wr && clr_wdata[2] && !fifo_underrun) |=> !raw_stat[2]);

    // R6
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (if_en && !drain_evt && !cfg_wr && !ien_wr && !clr_wr) |=> $stable(raw_stat));

    // R7
    mask_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_stat & ~raw_stat) == '0);

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|masked_stat) |=> irq);

    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|masked_stat) |=> !irq);

    // R9
    disable_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !if_en |=> (raw_stat == '0));
endmodule

bind chan_irq_status chan_irq_status_chk #(.STAT_W(STAT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .if_en         (if_en),
    .drain_evt     (drain_evt),
    .cfg_wr        (cfg_wr),
    .fifo_underrun (fifo_underrun),
    .fifo_empty    (fifo_empty),
    .tx_busy       (tx_busy),
    .ien_wr        (ien_wr),
    .clr_wr        (clr_wr),
    .clr_wdata     (clr_wdata),
    .raw_stat      (raw_stat),
    .masked_stat   (masked_stat),
    .irq           (irq)
);

// File: tb/tb_chan_irq_status.sv
module tb_chan_irq_status;
    localparam int SW = 7;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic if_en = 1'b0, drain_evt = 1'b0, cfg_wr = 1'b0, fifo_underrun = 1'b0;
    logic fifo_half_empty = 1'b0, fifo_empty = 1'b0, tx_busy = 1'b0;
    logic ien_wr = 1'b0, clr_wr = 1'b0;
    logic [SW-1:0] ien_wdata = '0, clr_wdata = '0;
    logic [SW-1:0] raw_stat, masked_stat;
    logic irq;
    logic [DW-1:0] rd_data;

    chan_irq_status #(.STAT_W(SW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .if_en(if_en), .drain_evt(drain_evt),
        .cfg_wr(cfg_wr), .fifo_underrun(fifo_underrun),
        .fifo_half_empty(fifo_half_empty), .fifo_empty(fifo_empty),
        .tx_busy(tx_busy), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata), .raw_stat(raw_stat),
        .masked_stat(masked_stat), .irq(irq), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    typedef struct {
        string         tag;
        logic [SW-1:0] raw;
        logic [SW-1:0] msk;
        logic          irq;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state, built from the requirements
    logic          m_ur = 1'b0;
    logic [SW-1:0] m_raw = '0;
    logic [SW-1:0] m_ien = '0;

    task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic en, logic drn, logic cfg, logic und,
                        logic hf, logic emp, logic bsy,
                        logic iw, logic [SW-1:0] id, logic cw, logic [SW-1:0] cd);
        exp_t e;
        logic ref_ev;
        logic ur_n;
        logic [SW-1:0] ien_n, raw_n;
        @(negedge clk);
        if_en = en; drain_evt = drn; cfg_wr = cfg; fifo_underrun = und;
        fifo_half_empty = hf; fifo_empty = emp; tx_busy = bsy;
        ien_wr = iw; ien_wdata = id; clr_wr = cw; clr_wdata = cd;
        ref_ev = drn | cfg | iw | cw;
        ien_n = iw ? id : m_ien;
        if (!en) begin
            ur_n  = 1'b0;
            raw_n = '0;
        end else begin
            ur_n  = und ? 1'b1 : ((cw && cd[2]) ? 1'b0 : m_ur);
            raw_n = m_raw;
            if (ref_ev) raw_n = {4'b0000, ur_n, emp & ~bsy, hf};
        end
        e.tag = tag;
        e.raw = raw_n;
        e.msk = raw_n & ien_n;
        e.irq = |(m_raw & m_ien);
        q.push_back(e);
        m_ur = ur_n; m_raw = raw_n; m_ien = ien_n;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "raw_stat", {{(DW-SW){1'b0}}, raw_stat}, {{(DW-SW){1'b0}}, e.raw});
                check(e.tag, "masked_stat", {{(DW-SW){1'b0}}, masked_stat}, {{(DW-SW){1'b0}}, e.msk});
                check(e.tag, "irq", {{(DW-1){1'b0}}, irq}, {{(DW-1){1'b0}}, e.irq});
                // R10
                check(e.tag, "rd_data", rd_data, {{(DW-SW){1'b0}}, e.raw});
            end
        end
    end

    // watchdog
    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", "raw_stat", {{(DW-SW){1'b0}}, raw_stat}, '0);
        check("R1", "masked_stat", {{(DW-SW){1'b0}}, masked_stat}, '0);
        check("R1", "irq", {{(DW-1){1'b0}}, irq}, '0);
        check("R1", "rd_data", rd_data, '0);

        //     tag   en drn cfg und hf emp bsy iw  id     cw  cd
        step("R1",  1, 0, 0, 0, 0, 0, 0, 0, 7'h00, 0, 7'h00);
        step("R2",  1, 1, 0, 0, 1, 0, 1, 0, 7'h00, 0, 7'h00);
        step("R6",  1, 0, 0, 0, 0, 1, 0, 0, 7'h00, 0, 7'h00);
        step("R3",  1, 0, 1, 0, 0, 1, 0, 0, 7'h00, 0, 7'h00);
        step("R3",  1, 1, 0, 0, 0, 1, 1, 0, 7'h00, 0, 7'h00);
        step("R7",  1, 0, 0, 0, 1, 0, 0, 1, 7'h07, 0, 7'h00);
        step("R8",  1, 0, 0, 0, 1, 0, 0, 0, 7'h00, 0, 7'h00);
        step("R4",  1, 1, 0, 1, 1, 1, 0, 0, 7'h00, 0, 7'h00);
        step("R4",  1, 1, 0, 0, 0, 0, 1, 0, 7'h00, 0, 7'h00);
        step("R5",  1, 0, 0, 0, 0, 0, 1, 0, 7'h00, 1, 7'h03);
        step("R5",  1, 1, 0, 1, 0, 0, 1, 0, 7'h00, 1, 7'h04);
        step("R5",  1, 0, 0, 0, 0, 0, 1, 0, 7'h00, 1, 7'h04);
        step("R8",  1, 0, 0, 0, 0, 0, 1, 0, 7'h00, 0, 7'h00);
        step("R7",  1, 1, 0, 1, 0, 1, 0, 1, 7'h02, 0, 7'h00);
        step("R9",  0, 1, 0, 1, 1, 1, 0, 0, 7'h00, 0, 7'h00);
        step("R9",  1, 1, 0, 0, 0, 0, 1, 0, 7'h00, 0, 7'h00);
        step("R10", 1, 1, 0, 0, 1, 1, 0, 0, 7'h00, 0, 7'h00);
        step("R8",  1, 0, 0, 0, 0, 0, 0, 0, 7'h00, 0, 7'h00);
        step("R6",  1, 0, 0, 0, 0, 0, 0, 0, 7'h00, 0, 7'h00);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule